// File: doc/BRIEF.md
# Wake-Up Status and Debounce Controller

This block records why a low-power radio transceiver came out of its sleep state and reports that through a small status word with a level interrupt. Two wake sources are watched. The first is an active-low power request pin, which is filtered by a restartable debounce counter whenever the device sits in one of its active modes. The second is a wake pin that acts on its rising edge. The block also sees the operating mode, a flag that warns that the RAM supply dropped too low, and a strobe that marks a read of the status word.

The status word holds three bits: the filtered request level, a wake-edge flag and a RAM-lost flag. A read clears the wake and RAM-lost flags and drops the interrupt, but leaves the request level alone. While the wake flag is set, the clock-enable output is held high whatever the configured clock-enable value is. Both pins pass through a two-stage synchronizer before any edge detection.

Top module: `wake_status_ctrl`

## Requirements
- R1: During and right after reset, st_req_o, st_wake_o, st_ram_lost_o and irq_o are 0, and clk_en_o follows clk_on_cfg_i.
- R2: In an active mode (mode_i 1 to 5), a level change on pwr_req_n_i that then stays stable updates st_req_o to the inverse of the pin (pin 0 gives 1) and sets irq_o. This happens DEB_CNT+4 rising clock edges after the change is applied, and not one edge earlier.
- R3: Every new edge on the synchronized request pin restarts the debounce window from zero. When the window ends, irq_o is raised even if the pin's level is the same as before.
- R4: In OFF mode (mode_i = 0), changes on pwr_req_n_i leave st_req_o unchanged and raise no interrupt.
- R5: A rising edge on wake_i sets st_wake_o and irq_o on the third rising clock edge after it is applied.
- R6: clk_en_o is 1 whenever st_wake_o is 1, and equals clk_on_cfg_i otherwise.
- R7: st_ram_lost_o is set by a change of mode_i from OFF (0) to IDLE (1), and also on every cycle in which ram_low_i is 1.
- R8: On the cycle mode_i goes from OFF to IDLE, st_req_o is loaded with the inverse of the synchronized request pin, and irq_o is raised only if that pin is low.
- R9: A rd_stb_i pulse clears st_wake_o, st_ram_lost_o and irq_o on the next edge. st_req_o is never changed by a read.
- R10: When a set event for a bit arrives in the same cycle as rd_stb_i, the bit ends set: the set takes priority over the clear.
- R11: irq_o is a level that stays at 1 until a read clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock, also the debounce clock |
| rst_i | input | 1 | Synchronous active-high reset |
| pwr_req_n_i | input | 1 | Active-low power request pin, asynchronous |
| wake_i | input | 1 | Rising-edge wake pin, asynchronous |
| mode_i | input | 3 | Operating mode: 0 OFF, 1 IDLE, 2 TX, 3 RX, 4 RX polling, 5 FD |
| ram_low_i | input | 1 | RAM supply was too low |
| rd_stb_i | input | 1 | One-cycle strobe marking a status read |
| clk_on_cfg_i | input | 1 | Configured clock-enable value |
| st_req_o | output | 1 | Filtered request status, inverse of the pin |
| st_wake_o | output | 1 | Wake edge seen since the last read |
| st_ram_lost_o | output | 1 | RAM contents may be lost |
| clk_en_o | output | 1 | Clock-enable control bit |
| irq_o | output | 1 | Level interrupt |

## Verification
A status read and a new set event can land in the same clock cycle: a wake edge reaching the status logic, or the RAM supply-low flag, against a read strobe. The bench tests every combination of wake event, supply-low flag and read strobe. It first sets all the flags, then lines the wake edge up three cycles ahead so that it arrives in the cycle of the strobe. It then computes each flag as the set event OR'ed with the old value masked by the read. A second kind of overlap is a new pin edge arriving while a debounce window is still open. This is provoked with a short glitch, and the check is that the update and interrupt come one full window after the second edge, not after the first.

// File: rtl/wsc_pkg.sv
package wsc_pkg;

    typedef enum logic [2:0] {
        MODE_OFF    = 3'd0,
        MODE_IDLE   = 3'd1,
        MODE_TX     = 3'd2,
        MODE_RX     = 3'd3,
        MODE_RXPOLL = 3'd4,
        MODE_FD     = 3'd5
    } op_mode_e;

    // set requests handed to the status register in one cycle
    typedef struct packed {
        logic wake;
        logic ram;
        logic req_upd;
        logic req_val;
        logic irq;
    } set_ev_t;

    typedef struct packed {
        logic req;
        logic wake;
        logic ram_lost;
    } status_t;

    function automatic logic mode_is_active(input logic [2:0] m);
        return (m >= 3'(MODE_IDLE)) && (m <= 3'(MODE_FD));
    endfunction

    function automatic logic mode_is_idle(input logic [2:0] m);
        return m == 3'(MODE_IDLE);
    endfunction

    function automatic logic mode_is_off(input logic [2:0] m);
        return m == 3'(MODE_OFF);
    endfunction

endpackage

// File: rtl/wsc_sync.sv
module wsc_sync #(
    parameter int               WIDTH   = 2,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            logic [STAGES-1:0] sh;
            always_ff @(posedge clk) begin
                if (rst) begin
                    sh <= {STAGES{RST_VAL[i]}};
                end else begin
                    sh <= {sh[STAGES-2:0], d[i]};
                end
            end
            assign q[i] = sh[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/wsc_debounce.sv
module wsc_debounce #(
    parameter int DEB_CNT = 8195
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_s,
    input  logic active,
    output logic done_o,
    output logic level_o
);

    localparam int            CW   = $clog2(DEB_CNT + 1);
    localparam logic [CW-1:0] LAST = CW'(DEB_CNT);

    logic          prev;
    logic          run;
    logic [CW-1:0] cnt;
    logic          pin_edge;

    assign pin_edge = pin_s ^ prev;
    assign done_o   = active && run && !pin_edge && (cnt == LAST);
    assign level_o  = pin_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev <= 1'b1;
            run  <= 1'b0;
            cnt  <= '0;
        end else begin
            prev <= pin_s;
            if (!active) begin
                run <= 1'b0;
                cnt <= '0;
            end else if (pin_edge) begin
                run <= 1'b1;
                cnt <= '0;
            end else if (done_o) begin
                run <= 1'b0;
            end else if (run) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/wsc_status.sv
module wsc_status
    import wsc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  set_ev_t ev,
    input  logic    rd_stb,
    output status_t st,
    output logic    irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= '0;
            irq <= 1'b0;
        end else begin
            if (ev.req_upd) begin
                st.req <= ev.req_val;
            end
            st.wake     <= ev.wake | (st.wake & ~rd_stb);
            st.ram_lost <= ev.ram  | (st.ram_lost & ~rd_stb);
            irq         <= ev.irq  | (irq & ~rd_stb);
        end
    end

endmodule

// File: rtl/wake_status_ctrl.sv
module wake_status_ctrl
    import wsc_pkg::*;
#(
    parameter int DEB_CNT     = 8195,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       pwr_req_n_i,
    input  logic       wake_i,
    input  logic [2:0] mode_i,
    input  logic       ram_low_i,
    input  logic       rd_stb_i,
    input  logic       clk_on_cfg_i,
    output logic       st_req_o,
    output logic       st_wake_o,
    output logic       st_ram_lost_o,
    output logic       clk_en_o,
    output logic       irq_o
);

    localparam int PIN_REQ  = 0;
    localparam int PIN_WAKE = 1;

    logic [1:0] pins_s;
    logic       wake_prev;
    logic       wake_rise;
    logic [2:0] mode_prev;
    logic       off_to_idle;
    logic       deb_done;
    logic       deb_level;
    set_ev_t    ev;
    status_t    st;
    logic       irq;

    wsc_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES),
        .RST_VAL(2'b01)
    ) u_sync (
        .clk(clk_i),
        .rst(rst_i),
        .d  ({wake_i, pwr_req_n_i}),
        .q  (pins_s)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            wake_prev <= 1'b0;
            mode_prev <= 3'(MODE_OFF);
        end else begin
            wake_prev <= pins_s[PIN_WAKE];
            mode_prev <= mode_i;
        end
    end

    assign wake_rise   = pins_s[PIN_WAKE] & ~wake_prev;
    assign off_to_idle = mode_is_off(mode_prev) && mode_is_idle(mode_i);

    wsc_debounce #(
        .DEB_CNT(DEB_CNT)
    ) u_deb (
        .clk    (clk_i),
        .rst    (rst_i),
        .pin_s  (pins_s[PIN_REQ]),
        .active (mode_is_active(mode_i)),
        .done_o (deb_done),
        .level_o(deb_level)
    );

    always_comb begin
        ev.wake    = wake_rise;
        ev.ram     = ram_low_i | off_to_idle;
        ev.req_upd = deb_done | off_to_idle;
        ev.req_val = ~deb_level;
        ev.irq     = wake_rise | deb_done | (off_to_idle & ~pins_s[PIN_REQ]);
    end

    wsc_status u_status (
        .clk   (clk_i),
        .rst   (rst_i),
        .ev    (ev),
        .rd_stb(rd_stb_i),
        .st    (st),
        .irq   (irq)
    );

    assign st_req_o      = st.req;
    assign st_wake_o     = st.wake;
    assign st_ram_lost_o = st.ram_lost;
    assign irq_o         = irq;
    assign clk_en_o      = clk_on_cfg_i | st.wake;

endmodule

// File: rtl/wake_status_ctrl_chk.sv
module wake_status_ctrl_chk
    import wsc_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic [2:0] mode,
    input logic       rd_stb,
    input logic       st_req,
    input logic       st_wake,
    input logic       st_ram_lost,
    input logic       clk_en,
    input logic       irq,
    input logic       ev_irq,
    input logic       ev_wake,
    input logic       ev_ram
);

    // R11: interrupt level holds without a read
    a_r11_irq_held: assert property (@(posedge clk) disable iff (rst)
        (irq && !rd_stb) |=> irq);

    // R9: read with no new interrupt source drops irq
    a_r9_read_drops_irq: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && !ev_irq) |=> !irq);

    // R9: read with no new wake edge clears the wake flag
    a_r9_read_clears_wake: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && !ev_wake) |=> !st_wake);

    // R10: a set request wins over a simultaneous read
    a_r10_irq_set_wins: assert property (@(posedge clk) disable iff (rst)
        ev_irq |=> irq);

    a_r10_ram_set_wins: assert property (@(posedge clk) disable iff (rst)
        ev_ram |=> st_ram_lost);

    // R6: wake flag forces clock enable
    a_r6_wake_forces_clk: assert property (@(posedge clk) disable iff (rst)
        st_wake |-> clk_en);

    // R5: wake flag rising comes with an interrupt
    a_r5_wake_has_irq: assert property (@(posedge clk) disable iff (rst)
        $rose(st_wake) |-> irq);

    // R4: request status frozen while staying in OFF
    a_r4_off_freeze: assert property (@(posedge clk) disable iff (rst)
        (mode_is_off(mode) && mode_is_off($past(mode))) |=> $stable(st_req));

endmodule

bind wake_status_ctrl wake_status_ctrl_chk u_chk (
    .clk        (clk_i),
    .rst        (rst_i),
    .mode       (mode_i),
    .rd_stb     (rd_stb_i),
    .st_req     (st_req_o),
    .st_wake    (st_wake_o),
    .st_ram_lost(st_ram_lost_o),
    .clk_en     (clk_en_o),
    .irq        (irq_o),
    .ev_irq     (ev.irq),
    .ev_wake    (ev.wake),
    .ev_ram     (ev.ram)
);

// File: tb/wake_status_ctrl_bench.sv
module wake_status_ctrl_bench;

    localparam int DEB = 20;

    logic       clk = 1'b0;
    logic       rst;
    logic       pin_n;
    logic       wake;
    logic [2:0] mode;
    logic       ram_low;
    logic       rd;
    logic       cfg;
    logic       st_req, st_wake, st_ram, clk_en, irq;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    wake_status_ctrl #(.DEB_CNT(DEB), .SYNC_STAGES(2)) u_wake_status_ctrl (
        .clk_i        (clk),
        .rst_i        (rst),
        .pwr_req_n_i  (pin_n),
        .wake_i       (wake),
        .mode_i       (mode),
        .ram_low_i    (ram_low),
        .rd_stb_i     (rd),
        .clk_on_cfg_i (cfg),
        .st_req_o     (st_req),
        .st_wake_o    (st_wake),
        .st_ram_lost_o(st_ram),
        .clk_en_o     (clk_en),
        .irq_o        (irq)
    );

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic check(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic do_read();
        rd = 1'b1;
        edges(1);
        rd = 1'b0;
    endtask

    initial begin
        #(8 * 100000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; pin_n = 1'b1; wake = 1'b0; mode = 3'd0;
        ram_low = 1'b0; rd = 1'b0; cfg = 1'b0;
        edges(5);
        check("R1 st_req in reset", st_req, 1'b0);
        check("R1 irq in reset", irq, 1'b0);
        rst = 1'b0;
        edges(1);
        check("R1 st_req", st_req, 1'b0);
        check("R1 st_wake", st_wake, 1'b0);
        check("R1 st_ram", st_ram, 1'b0);
        check("R1 irq", irq, 1'b0);
        check("R1 clk_en", clk_en, 1'b0);
        cfg = 1'b1; #1;
        check("R6 clk_en from cfg", clk_en, 1'b1);
        cfg = 1'b0; #1;

        // R4: OFF mode ignores the request pin
        pin_n = 1'b0;
        edges(2 * DEB + 10);
        check("R4 st_req frozen in OFF", st_req, 1'b0);
        check("R4 no irq in OFF", irq, 1'b0);

        // R8/R7: OFF to IDLE with pin low
        mode = 3'd1;
        edges(1);
        check("R8 st_req loaded low pin", st_req, 1'b1);
        check("R8 irq on low pin", irq, 1'b1);
        check("R7 ram lost on OFF->IDLE", st_ram, 1'b1);
        do_read();
        check("R9 read clears ram", st_ram, 1'b0);
        check("R9 read clears irq", irq, 1'b0);
        check("R9 read keeps st_req", st_req, 1'b1);

        // R2: exact debounce timing, pin released
        pin_n = 1'b1;
        edges(DEB + 3);
        check("R2 st_req not early", st_req, 1'b1);
        check("R2 irq not early", irq, 1'b0);
        edges(1);
        check("R2 st_req updated", st_req, 1'b0);
        check("R2 irq raised", irq, 1'b1);
        edges(15);
        check("R11 irq held", irq, 1'b1);
        do_read();
        check("R9 irq cleared", irq, 1'b0);

        // R3: glitch restarts window, irq with unchanged level
        pin_n = 1'b0;
        edges(5);
        pin_n = 1'b1;
        edges(DEB + 3);
        check("R3 no irq before restarted window", irq, 1'b0);
        check("R3 st_req unchanged", st_req, 1'b0);
        edges(1);
        check("R3 irq after restarted window", irq, 1'b1);
        check("R3 st_req same level", st_req, 1'b0);
        do_read();

        // R8: OFF to IDLE with pin high
        mode = 3'd0;
        edges(3);
        mode = 3'd1;
        edges(1);
        check("R8 st_req high pin", st_req, 1'b0);
        check("R8 no irq high pin", irq, 1'b0);
        check("R7 ram lost again", st_ram, 1'b1);
        do_read();

        // R2 in another active mode (TX)
        mode = 3'd2;
        edges(2);
        pin_n = 1'b0;
        edges(DEB + 4);
        check("R2 TX mode update", st_req, 1'b1);
        check("R2 TX mode irq", irq, 1'b1);
        do_read();
        pin_n = 1'b1;
        edges(DEB + 4);
        check("R2 TX mode release", st_req, 1'b0);
        do_read();
        mode = 3'd1;
        edges(2);

        // R5/R6: wake edge
        wake = 1'b1;
        edges(2);
        check("R5 wake not early", st_wake, 1'b0);
        edges(1);
        check("R5 wake set", st_wake, 1'b1);
        check("R5 wake irq", irq, 1'b1);
        check("R6 clk_en forced", clk_en, 1'b1);
        wake = 1'b0;
        edges(3);
        do_read();
        check("R9 wake cleared", st_wake, 1'b0);
        check("R6 clk_en released", clk_en, 1'b0);

        // R7: ram_low level
        ram_low = 1'b1;
        edges(1);
        ram_low = 1'b0;
        check("R7 ram_low sets flag", st_ram, 1'b1);
        do_read();

        // R10: sweep of wake event, ram flag, read in one cycle
        for (int c = 0; c < 8; c++) begin
            logic w, r, d;
            w = c[0]; r = c[1]; d = c[2];
            // preset all flags
            wake = 1'b1;
            edges(3);
            wake = 1'b0;
            ram_low = 1'b1;
            edges(1);
            ram_low = 1'b0;
            edges(3);
            // event and read aligned on the third edge
            wake = w;
            edges(2);
            ram_low = r;
            rd = d;
            edges(1);
            ram_low = 1'b0;
            rd = 1'b0;
            check($sformatf("R10 wake w=%0b r=%0b d=%0b", w, r, d), st_wake, w | ~d);
            check($sformatf("R10 ram w=%0b r=%0b d=%0b", w, r, d), st_ram, r | ~d);
            check($sformatf("R10 irq w=%0b r=%0b d=%0b", w, r, d), irq, w | ~d);
            check($sformatf("R9 st_req kept c=%0d", c), st_req, 1'b0);
            wake = 1'b0;
            edges(3);
            do_read();
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule